// File: doc/BRIEF.md
# Frame-Size-Dependent SPI Data FIFO

This block is the word buffer that sits between the bus side of an SPI controller and its serial shifter. The same block serves as the transmit queue or as the receive queue. It holds up to 32 words of 32 bits. The number of slots in use, called the effective depth, is picked at run time. A small fixed depth applies while the large-buffer enable is low. When the enable is high, the depth shrinks as the programmed frame size grows, so that wide frames keep a bounded amount of data in flight.

The producer pushes words, and the consumer pops them. Read data comes from a registered output, so the storage can map onto block RAM. The block reports empty, full, and one-short-of-full. In receive use it also keeps a sticky overflow flag, which records a word that arrived while the buffer was full. A synchronous clear throws away all contents.

Top module: `spf_fifo`

## Requirements
- R1: With `big_en` low, the effective depth is 4, so `full` rises on the 4th accepted push.
- R2: With `big_en` high, the effective depth is 32 for `frame_sz` 0..8, 16 for 9..16, and 8 for 17 and above (`frame_sz` is an unsigned 6-bit bit count).
- R3: A push while occupancy equals the effective depth is dropped, and the stored words and their order stay unchanged.
- R4: When `rx_mode` is 1, a push while full sets `overflow`, which then holds until it is cleared. When `rx_mode` is 0, such a push leaves `overflow` at 0.
- R5: A pop clears `overflow`. A dropped push in the same cycle takes priority and keeps it set.
- R6: `full_next` is 1 exactly when occupancy equals depth minus one, and `full` is 1 exactly when occupancy equals the depth. Both fall again as words are popped.
- R7: `empty` is 1 exactly when occupancy is 0. A pop while empty has no effect.
- R8: A `clr` pulse makes the FIFO empty and sets `empty`=1, `full`=0, `full_next`=0 and `overflow`=0 on the next cycle.
- R9: Words leave in the order they were accepted. `pop_data` shows the popped word from the clock edge that samples `pop`.
- R10: A push and a pop in the same cycle, with the FIFO neither empty nor full, keep the occupancy unchanged. The storage index wraps at the effective depth.
- R11: After `rst`, the outputs are `empty`=1, `full`=0, `full_next`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous flush of all contents |
| big_en | input | 1 | Large-buffer enable; when high, the depth follows `frame_sz` |
| frame_sz | input | 6 | Frame size in bits |
| rx_mode | input | 1 | 1 selects receive use, which enables overflow tracking |
| push | input | 1 | Write request |
| push_data | input | 32 | Word to write |
| pop | input | 1 | Read request |
| pop_data | output | 32 | Registered word read by the last accepted pop |
| empty | output | 1 | No words stored |
| full | output | 1 | Occupancy equals the effective depth |
| full_next | output | 1 | Occupancy equals the effective depth minus one |
| overflow | output | 1 | Sticky flag: a receive word was dropped |

## Verification
The embedded assertions check the following on every cycle:
- Occupancy never exceeds the effective depth.
- `full` and `empty` are never high together.
- A dropped push leaves the occupancy unchanged.
- `overflow` only rises after a dropped push in receive mode.
- A clear always leads to an empty state.
- The selected depth is always one of the legal values.

Data ordering, the exact depth for each frame-size band, pointer wrap under simultaneous traffic, and the preservation of contents after dropped words can only be shown by the bench's directed scenarios. Those scenarios compare the popped words against an independent queue model.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic full_next;
  } spf_flags_t;
endpackage

// File: rtl/spf_depth_sel.sv
module spf_depth_sel #(
  parameter int SLOTS       = 32,
  parameter int FS_W        = 6,
  parameter int SMALL_DEPTH = 4,
  parameter int MID_DEPTH   = 16,
  parameter int WIDE_DEPTH  = 8,
  parameter int NARROW_MAX  = 8,
  parameter int MID_MAX     = 16,
  localparam int CNT_W      = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             big_en,
  input  logic [FS_W-1:0]  frame_sz,
  output logic [CNT_W-1:0] depth
);
  always_comb begin
    if (!big_en)                        depth = CNT_W'(SMALL_DEPTH);
    else if (frame_sz <= FS_W'(NARROW_MAX)) depth = CNT_W'(SLOTS);
    else if (frame_sz <= FS_W'(MID_MAX))    depth = CNT_W'(MID_DEPTH);
    else                                depth = CNT_W'(WIDE_DEPTH);
  end

  // R1 R2: depth is always one of the legal values and tracks the enable
  assert_depth_legal_R2: assert property (@(posedge clk) disable iff (rst)
    big_en |-> (depth == CNT_W'(SLOTS) || depth == CNT_W'(MID_DEPTH) ||
                depth == CNT_W'(WIDE_DEPTH)));
  assert_depth_small_R1: assert property (@(posedge clk) disable iff (rst)
    !big_en |-> depth == CNT_W'(SMALL_DEPTH));
endmodule

// File: rtl/spf_store.sv
module spf_store #(
  parameter int WORD_W = 32,
  parameter int SLOTS  = 32,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/spf_ctrl.sv
module spf_ctrl
  import spf_pkg::*;
#(
  parameter int SLOTS  = 32,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic             rx_mode,
  input  logic [CNT_W-1:0] depth,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic             rd_en,
  output logic [PTR_W-1:0] rd_addr,
  output spf_flags_t       flags,
  output logic             overflow
);
  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             at_depth, drop;

  assign at_depth = (count >= depth);
  assign wr_en    = push && !at_depth && !clr;
  assign rd_en    = pop && (count != '0) && !clr;
  assign drop     = push && at_depth && !clr;
  assign wr_addr  = wr_ptr;
  assign rd_addr  = rd_ptr;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                input logic [CNT_W-1:0] d);
    if ({1'b0, p} >= d - CNT_W'(1)) return '0;
    return p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count    <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= step_ptr(wr_ptr, depth);
      if (rd_en) rd_ptr <= step_ptr(rd_ptr, depth);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (drop && rx_mode) overflow <= 1'b1;
      else if (pop)        overflow <= 1'b0;
    end
  end

  always_comb begin
    flags.empty     = (count == '0);
    flags.full      = at_depth;
    flags.full_next = (count == depth - CNT_W'(1));
  end

  // R6: occupancy never exceeds the effective depth
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    count <= depth);
  // R7: full and empty are exclusive
  assert_full_excl_empty_R7: assert property (@(posedge clk) disable iff (rst)
    !(flags.full && flags.empty));
  // R3: a dropped push without a pop leaves the occupancy unchanged
  assert_drop_keeps_count_R3: assert property (@(posedge clk) disable iff (rst)
    (drop && !pop) |=> $stable(count));
  // R4: overflow rises only after a dropped receive push
  assert_ovf_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(drop && rx_mode));
  // R8: clear empties the FIFO and drops overflow
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (flags.empty && !overflow));
endmodule

// File: rtl/spf_fifo.sv
module spf_fifo
  import spf_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SLOTS       = 32,
  parameter int FS_W        = 6,
  parameter int SMALL_DEPTH = 4,
  parameter int MID_DEPTH   = 16,
  parameter int WIDE_DEPTH  = 8,
  parameter int NARROW_MAX  = 8,
  parameter int MID_MAX     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              big_en,
  input  logic [FS_W-1:0]   frame_sz,
  input  logic              rx_mode,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] pop_data,
  output logic              empty,
  output logic              full,
  output logic              full_next,
  output logic              overflow
);
  localparam int PTR_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [CNT_W-1:0] depth;
  logic             wr_en, rd_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  spf_flags_t       flags;

  spf_depth_sel #(
    .SLOTS(SLOTS), .FS_W(FS_W), .SMALL_DEPTH(SMALL_DEPTH),
    .MID_DEPTH(MID_DEPTH), .WIDE_DEPTH(WIDE_DEPTH),
    .NARROW_MAX(NARROW_MAX), .MID_MAX(MID_MAX)
  ) u_depth (
    .clk(clk), .rst(rst), .big_en(big_en), .frame_sz(frame_sz), .depth(depth)
  );

  spf_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .push(push), .pop(pop),
    .rx_mode(rx_mode), .depth(depth), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .flags(flags), .overflow(overflow)
  );

  spf_store #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(push_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(pop_data)
  );

  assign empty     = flags.empty;
  assign full      = flags.full;
  assign full_next = flags.full_next;
endmodule

// File: tb/spf_fifo_tb.sv
module spf_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1, clr = 1'b0, big_en = 1'b0, rx_mode = 1'b0;
  logic [5:0]  frame_sz = '0;
  logic        push = 1'b0, pop = 1'b0;
  logic [31:0] push_data = '0;
  logic [31:0] pop_data;
  logic        empty, full, full_next, overflow;

  int checks = 0, errors = 0;
  logic [31:0] model[$];

  always #4 clk = ~clk;

  spf_fifo dut_i (
    .clk(clk), .rst(rst), .clr(clr), .big_en(big_en), .frame_sz(frame_sz),
    .rx_mode(rx_mode), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .empty(empty), .full(full), .full_next(full_next),
    .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_push(input logic [31:0] d);
    push = 1'b1; push_data = d; step(); push = 1'b0;
    if (model.size() < 40) model.push_back(d);
  endtask

  task automatic do_pop(output logic [31:0] d);
    pop = 1'b1; step(); pop = 1'b0; d = pop_data;
  endtask

  task automatic do_clr();
    clr = 1'b1; step(); clr = 1'b0; model.delete();
  endtask

  task automatic t_reset();
    chk(empty == 1'b1, "R11 empty", 32'(empty), 1);
    chk(full == 1'b0 && full_next == 1'b0, "R11 full/full_next",
        32'({full, full_next}), 0);
    chk(overflow == 1'b0, "R11 overflow", 32'(overflow), 0);
  endtask

  task automatic t_small();
    logic [31:0] d;
    big_en = 1'b0; rx_mode = 1'b0;
    for (int i = 0; i < 3; i++) do_push(32'h100 + 32'(i));
    chk(full_next && !full, "R6 full_next at depth-1", 32'({full, full_next}), 1);
    chk(!empty, "R7 not empty", 32'(empty), 0);
    do_push(32'h103);
    chk(full && !full_next, "R1 full at 4", 32'({full, full_next}), 2);
    push = 1'b1; push_data = 32'hBAD; step(); push = 1'b0;
    chk(!overflow, "R4 no overflow in tx mode", 32'(overflow), 0);
    for (int i = 0; i < 4; i++) begin
      do_pop(d);
      chk(d == 32'h100 + 32'(i), "R9 order small", d, 32'h100 + 32'(i));
      if (i == 0) chk(!full && full_next, "R6 flags drop after pop",
                      32'({full, full_next}), 1);
    end
    chk(empty, "R7 empty after drain", 32'(empty), 1);
    do_pop(d);
    chk(empty && !full, "R7 pop on empty ignored", 32'({empty, full}), 2);
    model.delete();
  endtask

  task automatic t_depth(input logic [5:0] fs, input int exp_depth);
    int n = 0;
    big_en = 1'b1; frame_sz = fs; rx_mode = 1'b0;
    step();
    for (int i = 0; i < 40; i++) begin
      if (full) break;
      do_push(32'(i));
      n++;
      if (n == exp_depth - 1)
        chk(full_next, "R6 full_next big", 32'(full_next), 1);
    end
    chk(n == exp_depth, "R2 depth for frame size", 32'(n), 32'(exp_depth));
    do_clr();
    chk(empty && !full && !full_next, "R8 clear after fill",
        32'({empty, full, full_next}), 4);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    big_en = 1'b0; rx_mode = 1'b1;
    for (int i = 0; i < 4; i++) do_push(32'hA0 + 32'(i));
    push = 1'b1; push_data = 32'hDEAD; step();
    chk(overflow, "R4 overflow set", 32'(overflow), 1);
    step(); push = 1'b0; step();
    chk(overflow, "R4 overflow sticky", 32'(overflow), 1);
    do_pop(d);
    chk(d == 32'hA0, "R3 head unchanged", d, 32'hA0);
    chk(!overflow, "R5 pop clears overflow", 32'(overflow), 0);
    for (int i = 1; i < 4; i++) begin
      do_pop(d);
      chk(d == 32'hA0 + 32'(i), "R3 contents unchanged", d, 32'hA0 + 32'(i));
    end
    chk(empty, "R3 dropped word not stored", 32'(empty), 1);
    model.delete();
  endtask

  task automatic t_clear();
    logic [31:0] d;
    big_en = 1'b0; rx_mode = 1'b1;
    for (int i = 0; i < 5; i++) do_push(32'hC0 + 32'(i));
    chk(overflow, "R4 overflow before clear", 32'(overflow), 1);
    do_clr();
    chk(empty && !full && !full_next && !overflow, "R8 clear",
        32'({empty, full, full_next, overflow}), 8);
    do_push(32'h5A5A);
    do_pop(d);
    chk(d == 32'h5A5A, "R8 fresh data after clear", d, 32'h5A5A);
    model.delete();
  endtask

  task automatic t_simul();
    logic [31:0] exp;
    big_en = 1'b0; rx_mode = 1'b0;
    for (int i = 0; i < 3; i++) do_push(32'hE0 + 32'(i));
    for (int i = 0; i < 10; i++) begin
      push = 1'b1; pop = 1'b1; push_data = 32'hF0 + 32'(i);
      step(); push = 1'b0; pop = 1'b0;
      model.push_back(32'hF0 + 32'(i));
      exp = model.pop_front();
      chk(pop_data == exp, "R10 order through wrap", pop_data, exp);
      chk(full_next && !full && !empty, "R10 occupancy kept",
          32'({full_next, full, empty}), 4);
    end
    while (model.size() > 0) begin
      logic [31:0] d;
      exp = model.pop_front();
      do_pop(d);
      chk(d == exp, "R9 drain after wrap", d, exp);
    end
    chk(empty, "R7 empty after wrap drain", 32'(empty), 1);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_small();
    t_depth(6'd0, 32);
    t_depth(6'd8, 32);
    t_depth(6'd9, 16);
    t_depth(6'd16, 16);
    t_depth(6'd17, 8);
    t_depth(6'd32, 8);
    t_overflow();
    t_clear();
    t_simul();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule